// File: doc/BRIEF.md
# Acquisition Status and Error Flags

This block collects the condition flags of a data-acquisition front end into a single read-only status word. It watches the level of the conversion-result FIFO, the terminal-count pulses of two DMA channels, the start and done events of the converter, writes of new results into the FIFO, the ready signal of the output (DAC) FIFO and an active-low timer trigger. From these it keeps six flags. Some follow the FIFO level, some are sticky until a clear strobe, and one clears itself on a DAC write when DMA transfer mode is selected.

The flags drive a conversion interrupt, a timer interrupt and a timer DMA request, routed by a two-bit transfer mode input. When a FIFO overflow or a conversion overrun occurs while an acquisition is running, an abort output rises in the same cycle, so the sequencer can stop without losing another cycle. All flags reset synchronously to zero.

Top module: `acq_status_flags`

## Requirements
- R1: Status bit 12 (data available) is 1 exactly one cycle after a cycle in which `fifo_empty_i` is 0. The conversion interrupt equals that bit ANDed with `conv_irq_en_i`, so it drops only once the FIFO has been read empty.
- R2: DMA terminal-count flags sit at status bit 11 (channel A, `dma_tc_i[0]`) and bit 10 (channel B, `dma_tc_i[1]`). Each sets on its channel's terminal-count pulse and holds until that channel's own bit of `tc_clr_i`. The other channel's clear has no effect on it.
- R3: The overflow flag (status bit 9) sets in the cycle after `conv_wr_i` is high while `fifo_full_i` is high.
- R4: The overrun flag (status bit 8) sets after `conv_start_i` arrives while a conversion is in progress and `conv_done_i` is low. A start together with the done of the previous conversion is not an overrun.
- R5: While `acq_run_i` is high, `acq_abort_o` is high in the same cycle as an overflow or overrun event. It stays high while either error flag is set.
- R6: Overflow and overrun clear only on `acq_clr_i`. The terminal-count and timer clears leave them set.
- R7: The timer-request flag (status bit 7) sets when `dac_ready_i` is high. It also sets on a high-to-low transition of `tmr_trig_n_i` when the mode is interrupt. In any other mode that transition has no effect.
- R8: Mode encoding on `mode_i`: 0 is programmed I/O, 1 is interrupt, 2 is DMA. In DMA mode a `dac_wr_i` clears the timer request and `tmr_clr_i` has no effect. In the other modes only `tmr_clr_i` clears it and `dac_wr_i` has no effect.
- R9: `tmr_irq_o` is the timer request in interrupt mode only, and `tmr_dreq_o` is the timer request in DMA mode only.
- R10: If a flag has a set event and a clear in the same cycle, it ends up set.
- R11: After reset every flag is 0. Status bits 15..13 and 6..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty_i | input | 1 | Conversion FIFO holds no result |
| fifo_full_i | input | 1 | Conversion FIFO is full |
| conv_wr_i | input | 1 | A new conversion result is presented to the FIFO |
| conv_start_i | input | 1 | Conversion start event |
| conv_done_i | input | 1 | Conversion complete event |
| acq_run_i | input | 1 | An acquisition is in progress |
| acq_clr_i | input | 1 | Clears overflow and overrun |
| conv_irq_en_i | input | 1 | Conversion interrupt enable |
| dma_tc_i | input | 2 | Terminal-count pulse per DMA channel (bit 0 = A) |
| tc_clr_i | input | 2 | Terminal-count clear per DMA channel |
| mode_i | input | 2 | Transfer mode: 0 PIO, 1 interrupt, 2 DMA |
| dac_ready_i | input | 1 | Output FIFO can accept data |
| tmr_trig_n_i | input | 1 | Timer trigger, active low |
| dac_wr_i | input | 1 | DAC write |
| tmr_clr_i | input | 1 | Timer-request clear strobe |
| status_o | output | 16 | Status word |
| conv_irq_o | output | 1 | Conversion interrupt |
| tmr_irq_o | output | 1 | Timer interrupt request |
| tmr_dreq_o | output | 1 | Timer DMA request |
| acq_abort_o | output | 1 | Stop acquisition on error |

## Verification
Two cases can land on the same clock edge: a flag's set event and its clear. Tests cover the terminal count with its channel clear, overflow with the acquisition clear, DAC ready with a DAC write in DMA mode, and DAC ready with the timer clear in interrupt mode. The bench asserts both inputs in one cycle and expects the flag set after the edge. A second coincidence, start and done in the same cycle, is driven and checked to leave the overrun flag clear.

// File: rtl/acq_flags_pkg.sv
package acq_flags_pkg;
  localparam int STATUS_W  = 16;
  localparam int NUM_DMA   = 2;
  localparam int BIT_AVAIL = 12;
  localparam int BIT_TC_A  = 11;
  localparam int BIT_OVF   = 9;
  localparam int BIT_OVR   = 8;
  localparam int BIT_TMR   = 7;

  localparam logic [1:0] MODE_PIO = 2'd0;
  localparam logic [1:0] MODE_IRQ = 2'd1;
  localparam logic [1:0] MODE_DMA = 2'd2;

  // next state of a flag where a set beats a clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/acq_sticky_flag.sv
module acq_sticky_flag
  import acq_flags_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_next(flag_o, set_i, clr_i);
  end
endmodule

// File: rtl/acq_conv_monitor.sv
module acq_conv_monitor (
  input  logic clk,
  input  logic rst,
  input  logic conv_start_i,
  input  logic conv_done_i,
  input  logic conv_wr_i,
  input  logic fifo_full_i,
  output logic ovr_evt_o,
  output logic ovf_evt_o
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst)               busy_q <= 1'b0;
    else if (conv_start_i) busy_q <= 1'b1;
    else if (conv_done_i)  busy_q <= 1'b0;
  end

  assign ovr_evt_o = conv_start_i & busy_q & ~conv_done_i;
  assign ovf_evt_o = conv_wr_i & fifo_full_i;
endmodule

// File: rtl/acq_timer_req.sv
module acq_timer_req
  import acq_flags_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       dac_ready_i,
  input  logic       tmr_trig_n_i,
  input  logic       dac_wr_i,
  input  logic       tmr_clr_i,
  output logic       trig_fall_o,
  output logic       flag_o,
  output logic       irq_o,
  output logic       dreq_o
);
  logic trig_q;
  logic set_w;
  logic clr_w;
  logic is_dma;
  logic is_irq;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b1;
    else     trig_q <= tmr_trig_n_i;
  end

  assign is_dma      = (mode_i == MODE_DMA);
  assign is_irq      = (mode_i == MODE_IRQ);
  assign trig_fall_o = trig_q & ~tmr_trig_n_i;
  assign set_w       = dac_ready_i | (trig_fall_o & is_irq);
  assign clr_w       = is_dma ? dac_wr_i : tmr_clr_i;

  acq_sticky_flag u_flag (
    .clk(clk), .rst(rst), .set_i(set_w), .clr_i(clr_w), .flag_o(flag_o)
  );

  assign irq_o  = flag_o & is_irq;
  assign dreq_o = flag_o & is_dma;
endmodule

// File: rtl/acq_status_flags.sv
module acq_status_flags
  import acq_flags_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_empty_i,
  input  logic                fifo_full_i,
  input  logic                conv_wr_i,
  input  logic                conv_start_i,
  input  logic                conv_done_i,
  input  logic                acq_run_i,
  input  logic                acq_clr_i,
  input  logic                conv_irq_en_i,
  input  logic [NUM_DMA-1:0]  dma_tc_i,
  input  logic [NUM_DMA-1:0]  tc_clr_i,
  input  logic [1:0]          mode_i,
  input  logic                dac_ready_i,
  input  logic                tmr_trig_n_i,
  input  logic                dac_wr_i,
  input  logic                tmr_clr_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                conv_irq_o,
  output logic                tmr_irq_o,
  output logic                tmr_dreq_o,
  output logic                acq_abort_o
);
  logic               avail_q;
  logic [NUM_DMA-1:0] tc_q;
  logic               ovf_q;
  logic               ovr_q;
  logic               tmr_q;
  logic               ovf_evt;
  logic               ovr_evt;
  logic               trig_fall;

  always_ff @(posedge clk) begin
    if (rst) avail_q <= 1'b0;
    else     avail_q <= ~fifo_empty_i;
  end

  for (genvar ch = 0; ch < NUM_DMA; ch++) begin : g_tc
    acq_sticky_flag u_tc (
      .clk(clk), .rst(rst), .set_i(dma_tc_i[ch]), .clr_i(tc_clr_i[ch]), .flag_o(tc_q[ch])
    );
  end

  acq_conv_monitor u_mon (
    .clk(clk), .rst(rst),
    .conv_start_i(conv_start_i), .conv_done_i(conv_done_i),
    .conv_wr_i(conv_wr_i), .fifo_full_i(fifo_full_i),
    .ovr_evt_o(ovr_evt), .ovf_evt_o(ovf_evt)
  );

  acq_sticky_flag u_ovf (
    .clk(clk), .rst(rst), .set_i(ovf_evt), .clr_i(acq_clr_i), .flag_o(ovf_q)
  );
  acq_sticky_flag u_ovr (
    .clk(clk), .rst(rst), .set_i(ovr_evt), .clr_i(acq_clr_i), .flag_o(ovr_q)
  );

  acq_timer_req u_tmr (
    .clk(clk), .rst(rst), .mode_i(mode_i), .dac_ready_i(dac_ready_i),
    .tmr_trig_n_i(tmr_trig_n_i), .dac_wr_i(dac_wr_i), .tmr_clr_i(tmr_clr_i),
    .trig_fall_o(trig_fall), .flag_o(tmr_q), .irq_o(tmr_irq_o), .dreq_o(tmr_dreq_o)
  );

  always_comb begin
    status_o            = '0;
    status_o[BIT_AVAIL] = avail_q;
    for (int ch = 0; ch < NUM_DMA; ch++) status_o[BIT_TC_A - ch] = tc_q[ch];
    status_o[BIT_OVF]   = ovf_q;
    status_o[BIT_OVR]   = ovr_q;
    status_o[BIT_TMR]   = tmr_q;
  end

  assign conv_irq_o  = avail_q & conv_irq_en_i;
  assign acq_abort_o = acq_run_i & (ovf_evt | ovr_evt | ovf_q | ovr_q);
endmodule

// File: rtl/acq_status_flags_chk.sv
module acq_status_flags_chk
  import acq_flags_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                fifo_empty_i,
  input logic [NUM_DMA-1:0]  dma_tc_i,
  input logic [NUM_DMA-1:0]  tc_clr_i,
  input logic                acq_clr_i,
  input logic                acq_run_i,
  input logic [1:0]          mode_i,
  input logic                dac_ready_i,
  input logic                dac_wr_i,
  input logic                ovf_evt,
  input logic                ovr_evt,
  input logic [STATUS_W-1:0] status_o,
  input logic                acq_abort_o
);
  assert_empty_clears_avail_R1: assert property (@(posedge clk) disable iff (rst)
    fifo_empty_i |=> !status_o[BIT_AVAIL]);

  assert_tc_a_sets_R2: assert property (@(posedge clk) disable iff (rst)
    dma_tc_i[0] |=> status_o[BIT_TC_A]);

  assert_tc_a_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (status_o[BIT_TC_A] && !tc_clr_i[0]) |=> status_o[BIT_TC_A]);

  assert_overflow_sets_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> status_o[BIT_OVF]);

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> status_o[BIT_OVR]);

  assert_abort_now_R5: assert property (@(posedge clk) disable iff (rst)
    (acq_run_i && (ovf_evt || ovr_evt)) |-> acq_abort_o);

  assert_errors_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (status_o[BIT_OVF] && !acq_clr_i) |=> status_o[BIT_OVF]);

  assert_dma_wr_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_DMA && dac_wr_i && !dac_ready_i) |=> !status_o[BIT_TMR]);

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (status_o[15:13] == 3'b0) && (status_o[6:0] == 7'b0));
endmodule

bind acq_status_flags acq_status_flags_chk u_chk (
  .clk(clk), .rst(rst), .fifo_empty_i(fifo_empty_i), .dma_tc_i(dma_tc_i),
  .tc_clr_i(tc_clr_i), .acq_clr_i(acq_clr_i), .acq_run_i(acq_run_i),
  .mode_i(mode_i), .dac_ready_i(dac_ready_i), .dac_wr_i(dac_wr_i),
  .ovf_evt(ovf_evt), .ovr_evt(ovr_evt), .status_o(status_o), .acq_abort_o(acq_abort_o)
);

// File: tb/test_acq_status_flags.sv
`timescale 1ns/1ps
module test_acq_status_flags;
  logic        clk = 1'b0;
  logic        rst;
  logic        fifo_empty_i, fifo_full_i, conv_wr_i, conv_start_i, conv_done_i;
  logic        acq_run_i, acq_clr_i, conv_irq_en_i;
  logic [1:0]  dma_tc_i, tc_clr_i, mode_i;
  logic        dac_ready_i, tmr_trig_n_i, dac_wr_i, tmr_clr_i;
  logic [15:0] status_o;
  logic        conv_irq_o, tmr_irq_o, tmr_dreq_o, acq_abort_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  acq_status_flags i_acq_status_flags (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fifo_empty_i = 1; fifo_full_i = 0; conv_wr_i = 0; conv_start_i = 0; conv_done_i = 0;
    acq_run_i = 0; acq_clr_i = 0; conv_irq_en_i = 0; dma_tc_i = 0; tc_clr_i = 0;
    dac_ready_i = 0; tmr_trig_n_i = 1; dac_wr_i = 0; tmr_clr_i = 0;
  endtask

  // apply current inputs over one edge, then sample just after it
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive_start();
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    idle(); mode_i = 2'd0; rst = 1;
    step(); step();
    @(negedge clk); rst = 0;
    check("R11 status after reset", status_o, 16'h0000);
    check("R11 outputs after reset", {12'b0, conv_irq_o, tmr_irq_o, tmr_dreq_o, acq_abort_o}, 16'h0);
  endtask

  task automatic t_avail();
    drive_start(); fifo_empty_i = 0; conv_irq_en_i = 0; step();
    check("R1 avail bit", status_o, 16'h1000);
    check("R1 irq masked", {15'b0, conv_irq_o}, 16'h0);
    @(negedge clk); fifo_empty_i = 0; conv_irq_en_i = 1; step();
    check("R1 irq enabled", {15'b0, conv_irq_o}, 16'h1);
    @(negedge clk); fifo_empty_i = 1; conv_irq_en_i = 1; step();
    check("R1 read empty clears", {status_o[12], conv_irq_o}, 16'h0);
  endtask

  task automatic t_dma_tc();
    drive_start(); dma_tc_i = 2'b01; step();
    check("R2 tc A set", status_o, 16'h0800);
    @(negedge clk); idle(); tc_clr_i = 2'b10; step();
    check("R2 clear B leaves A", status_o, 16'h0800);
    @(negedge clk); idle(); dma_tc_i = 2'b10; tc_clr_i = 2'b01; step();
    check("R2 A cleared, B set", status_o, 16'h0400);
    @(negedge clk); idle(); dma_tc_i = 2'b10; tc_clr_i = 2'b10; step();
    check("R10 tc set beats clear", status_o, 16'h0400);
    @(negedge clk); idle(); tc_clr_i = 2'b10; step();
    check("R2 B cleared", status_o, 16'h0000);
  endtask

  task automatic t_overflow();
    drive_start(); acq_run_i = 1; conv_wr_i = 1; fifo_full_i = 0; #1;
    check("R5 no abort without error", {15'b0, acq_abort_o}, 16'h0);
    step();
    check("R3 write below full", status_o, 16'h0000);
    @(negedge clk); idle(); acq_run_i = 1; conv_wr_i = 1; fifo_full_i = 1; #1;
    check("R5 abort same cycle as overflow", {15'b0, acq_abort_o}, 16'h1);
    step();
    check("R3 overflow set", status_o, 16'h0200);
    @(negedge clk); idle(); acq_run_i = 1; tc_clr_i = 2'b11; tmr_clr_i = 1; step();
    check("R6 other clears keep overflow", status_o, 16'h0200);
    check("R5 abort held by flag", {15'b0, acq_abort_o}, 16'h1);
    @(negedge clk); idle(); acq_clr_i = 1; conv_wr_i = 1; fifo_full_i = 1; step();
    check("R10 overflow set beats acq clear", status_o, 16'h0200);
    @(negedge clk); idle(); acq_clr_i = 1; step();
    check("R6 acq clear", status_o, 16'h0000);
  endtask

  task automatic t_overrun();
    drive_start(); conv_start_i = 1; step();
    check("R4 first start no overrun", status_o, 16'h0000);
    @(negedge clk); idle(); conv_start_i = 1; conv_done_i = 1; step();
    check("R4 start with done no overrun", status_o, 16'h0000);
    @(negedge clk); idle(); acq_run_i = 1; conv_start_i = 1; #1;
    check("R5 abort same cycle as overrun", {15'b0, acq_abort_o}, 16'h1);
    step();
    check("R4 overrun set", status_o, 16'h0100);
    @(negedge clk); idle(); conv_done_i = 1; acq_clr_i = 1; step();
    check("R6 overrun cleared", status_o, 16'h0000);
  endtask

  task automatic t_timer();
    drive_start(); mode_i = 2'd0; tmr_trig_n_i = 0; step();
    check("R7 trigger ignored in PIO", status_o, 16'h0000);
    @(negedge clk); idle(); mode_i = 2'd1; step();
    @(negedge clk); tmr_trig_n_i = 0; step();
    check("R7 trigger sets in IRQ mode", status_o, 16'h0080);
    check("R9 irq in IRQ mode", {14'b0, tmr_irq_o, tmr_dreq_o}, 16'h2);
    @(negedge clk); idle(); dac_wr_i = 1; step();
    check("R8 DAC write ignored in IRQ mode", status_o, 16'h0080);
    @(negedge clk); idle(); tmr_clr_i = 1; dac_ready_i = 1; step();
    check("R10 ready beats timer clear", status_o, 16'h0080);
    @(negedge clk); idle(); tmr_clr_i = 1; step();
    check("R8 timer clear in IRQ mode", status_o, 16'h0000);
    @(negedge clk); idle(); mode_i = 2'd2; dac_ready_i = 1; step();
    check("R9 DMA request in DMA mode", {14'b0, tmr_irq_o, tmr_dreq_o}, 16'h1);
    @(negedge clk); idle(); tmr_clr_i = 1; step();
    check("R8 timer clear ignored in DMA mode", status_o, 16'h0080);
    @(negedge clk); idle(); dac_wr_i = 1; dac_ready_i = 1; step();
    check("R10 ready beats DAC write", status_o, 16'h0080);
    @(negedge clk); idle(); dac_wr_i = 1; step();
    check("R8 DAC write clears in DMA mode", status_o, 16'h0000);
    @(negedge clk); idle(); mode_i = 2'd0; dac_ready_i = 1; step();
    check("R9 no request in PIO", {14'b0, tmr_irq_o, tmr_dreq_o}, 16'h0);
    check("R7 ready sets in PIO", status_o, 16'h0080);
    @(negedge clk); idle(); tmr_clr_i = 1; step();
  endtask

  task automatic t_all_flags();
    drive_start(); fifo_empty_i = 0; dma_tc_i = 2'b11; conv_wr_i = 1; fifo_full_i = 1;
    dac_ready_i = 1; step();
    @(negedge clk); idle(); fifo_empty_i = 0; conv_start_i = 1; step();
    @(negedge clk); idle(); fifo_empty_i = 0; conv_start_i = 1; step();
    check("R11 only defined bits set", status_o, 16'h1F80);
  endtask

  initial begin
    t_reset();
    t_avail();
    t_dma_tc();
    t_overflow();
    t_overrun();
    t_timer();
    t_all_flags();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule